// File: doc/BRIEF.md
# Coulomb Accumulator with Offset Calibration

This block sits behind a signed current-measuring ADC and turns its stream of conversion results into a running net-charge total. At the end of each conversion it subtracts a stored offset from the raw sample and clamps the result to the configured resolution. It shows that result in a current register and adds it into a wide signed sum. The upper 16 bits of that sum are visible. The lower bits are a fraction that no port exposes.

The block also plans the ADC's offset calibration. One conversion in every period is flagged as an offset measurement. Its raw result becomes the new offset. During that slot the current register keeps its previous value, and the same value is added into the sum in place of the missing sample. A host may overwrite the visible total. Such a write zeroes the fraction and makes the next conversion an offset measurement. Accumulation then resumes with the conversion after that.

Top module: `coulomb_acc`

## Requirements
- R1: On an ordinary conversion the current register becomes raw sample minus stored offset, clamped to the signed range of MAG_BITS magnitude bits (±32768 minus one on the high side at the default of 15) and sign-extended to 16 bits.
- R2: The accumulator changes only at the edge where a conversion completes or a host write occurs. Each accumulating conversion adds the sign-extended current at the least significant bit of a 28-bit sum, and acc_reg shows bits 27..12 of that sum.
- R3: The 28-bit sum saturates at its most positive and most negative values instead of wrapping.
- R4: In an offset slot the raw sample is stored as the new offset. The current register holds its previous value, and that held value is added to the sum.
- R5: offset_next is 1 for exactly one conversion in every OFS_PERIOD (1024). After an offset slot, 1023 ordinary conversions follow before the next one.
- R6: Synchronous active-high reset clears the current register, the sum and the offset, and sets offset_next to 1.
- R7: A host write loads host_wdata into bits 27..12 of the sum, clears bits 11..0, and sets offset_next to 1.
- R8: The offset slot that follows a host write adds nothing to the sum. Accumulation resumes with the second conversion after the write.
- R9: When host_wr and conv_done are high in the same cycle, the write takes effect and that conversion is discarded.
- R10: With MAG_BITS = 13 the current register clamps to -8192..8191, sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_raw | input | 16 | Signed raw ADC result for that conversion |
| host_wr | input | 1 | Host write strobe for the accumulator |
| host_wdata | input | 16 | Signed value written to the visible accumulator |
| cur_reg | output | 16 | Signed offset-corrected current |
| acc_reg | output | 16 | Signed visible accumulated charge |
| offset_next | output | 1 | The next conversion must be an offset measurement |

## Verification
The bench runs more than one full calibration period without host writes. This catches an off-by-one period counter, which would flag the offset slot one conversion early or late. It checks that an offset slot both holds the current register and re-adds its value. A design that updated the current from the calibration sample, or skipped the substitute addition, would show a wrong current or a short total. It checks that the slot right after a host write adds nothing, and that a conversion arriving together with a write is dropped. It drives the sum into both saturation limits, where a wrapping adder would flip the sign of acc_reg. A reduced-resolution instance receives the same stimulus, and its clamping is checked at ±8192.

// File: rtl/coul_pkg.sv
package coul_pkg;

    localparam int unsigned REG_W = 16;

    typedef logic signed [REG_W-1:0] cur_t;
    typedef logic signed [REG_W:0]   wide_t;

    // per-conversion control from the slot scheduler
    typedef struct packed {
        logic valid;   // conversion accepted this cycle
        logic ofs;     // this conversion is an offset measurement
        logic no_add;  // first slot after a host write: add nothing
    } slot_t;

    // clamp a widened difference to a signed range of mag magnitude bits
    function automatic cur_t clamp_cur(input wide_t d, input int unsigned mag);
        wide_t hi;
        wide_t lo;
        hi = wide_t'((1 << mag) - 1);
        lo = -hi - wide_t'(1);
        if (d > hi) return cur_t'(hi);
        if (d < lo) return cur_t'(lo);
        return cur_t'(d);
    endfunction

endpackage

// File: rtl/coul_slot_sched.sv
module coul_slot_sched
    import coul_pkg::*;
#(
    parameter int unsigned OFS_PERIOD = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  conv_done,
    input  logic  host_wr,
    output slot_t slot
);
    localparam int unsigned CNT_W = (OFS_PERIOD > 1) ? $clog2(OFS_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OFS_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             post_wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            post_wr_q <= 1'b0;
        end else if (host_wr) begin
            cnt_q     <= '0;
            post_wr_q <= 1'b1;
        end else if (conv_done) begin
            cnt_q     <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            post_wr_q <= 1'b0;
        end
    end

    always_comb begin
        slot.valid  = conv_done && !host_wr;
        slot.ofs    = (cnt_q == '0);
        slot.no_add = post_wr_q;
    end

    AST_WR_FORCES_OFS: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> slot.ofs);  // R7

    AST_OFS_THEN_ORDINARY: assert property (@(posedge clk) disable iff (rst)
        (slot.valid && slot.ofs && OFS_PERIOD > 1) |=> !slot.ofs);  // R5

endmodule

// File: rtl/coul_offset_corr.sv
module coul_offset_corr
    import coul_pkg::*;
#(
    parameter int unsigned MAG_BITS = 15
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    input  cur_t  raw,
    output cur_t  cur_q,
    output cur_t  add_val
);
    cur_t  off_q;
    wide_t diff;
    cur_t  corr;

    always_comb begin
        diff    = wide_t'(raw) - wide_t'(off_q);
        corr    = clamp_cur(diff, MAG_BITS);
        add_val = slot.ofs ? cur_q : corr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            cur_q <= '0;
        end else if (slot.valid) begin
            if (slot.ofs) off_q <= raw;
            else          cur_q <= corr;
        end
    end

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slot.valid && slot.ofs) |=> $stable(cur_q));  // R4

    AST_CUR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wide_t'(cur_q) <= wide_t'((1 << MAG_BITS) - 1)) &&
        (wide_t'(cur_q) >= -wide_t'(1 << MAG_BITS)));  // R1

endmodule

// File: rtl/coul_charge_acc.sv
module coul_charge_acc
    import coul_pkg::*;
#(
    parameter int unsigned FRAC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slot,
    input  cur_t             add_val,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] acc_vis
);
    localparam int unsigned ACC_W = REG_W + FRAC_W;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [ACC_W:0]   sum_t;

    acc_t acc_q;
    sum_t sum;
    acc_t nxt;

    always_comb begin
        sum = sum_t'(acc_q) + sum_t'(add_val);
        if (sum[ACC_W] != sum[ACC_W-1])
            nxt = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else
            nxt = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (host_wr)
            acc_q <= {host_wdata, {FRAC_W{1'b0}}};
        else if (slot.valid && !slot.no_add)
            acc_q <= nxt;
    end

    assign acc_vis = acc_q[ACC_W-1:FRAC_W];

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (acc_vis == $past(host_wdata)));  // R7

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!slot.valid && !host_wr) |=> $stable(acc_q));  // R2

    AST_POST_WR_NOADD: assert property (@(posedge clk) disable iff (rst)
        (slot.valid && slot.no_add && !host_wr) |=> $stable(acc_q));  // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot.valid && !slot.no_add && !host_wr && add_val > 0 && $signed(acc_q) > 0)
            |=> $signed(acc_q) > 0);  // R3

endmodule

// File: rtl/coulomb_acc.sv
module coulomb_acc
    import coul_pkg::*;
#(
    parameter int unsigned MAG_BITS   = 15,
    parameter int unsigned FRAC_W     = 12,
    parameter int unsigned OFS_PERIOD = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        conv_done,
    input  logic [15:0] conv_raw,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    output logic [15:0] cur_reg,
    output logic [15:0] acc_reg,
    output logic        offset_next
);
    slot_t slot;
    cur_t  cur_q;
    cur_t  add_val;

    coul_slot_sched #(.OFS_PERIOD(OFS_PERIOD)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .host_wr   (host_wr),
        .slot      (slot)
    );

    coul_offset_corr #(.MAG_BITS(MAG_BITS)) u_corr (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .raw     (cur_t'(conv_raw)),
        .cur_q   (cur_q),
        .add_val (add_val)
    );

    coul_charge_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .add_val    (add_val),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .acc_vis    (acc_reg)
    );

    assign cur_reg     = cur_q;
    assign offset_next = slot.ofs;

endmodule

// File: tb/coulomb_acc_tb.sv
module coulomb_acc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [15:0] conv_raw = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] cur_reg, acc_reg, cur_lr, acc_lr;
    logic        offset_next, ofs_lr;

    always #5 clk = ~clk;

    coulomb_acc u_dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_raw(conv_raw),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .cur_reg(cur_reg), .acc_reg(acc_reg), .offset_next(offset_next)
    );

    coulomb_acc #(.MAG_BITS(13)) u_dut_lr (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_raw(conv_raw),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .cur_reg(cur_lr), .acc_reg(acc_lr), .offset_next(ofs_lr)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // reference model
    longint m_acc = 0;
    longint m_cur = 0;
    longint m_cur_lr = 0;
    longint m_off = 0;
    int     m_cnt = 0;
    bit     m_post = 0;

    function automatic longint clampl(input longint d, input int mag);
        longint hi;
        hi = (longint'(1) <<< mag) - 1;
        if (d > hi) return hi;
        if (d < -hi - 1) return -hi - 1;
        return d;
    endfunction

    function automatic longint sat_acc(input longint v);
        longint hi;
        hi = (longint'(1) <<< 27) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag,
                     $signed(act), $signed(exp));
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cur"}, cur_reg, 16'(m_cur));
        chk({tag, " acc"}, acc_reg, 16'(m_acc >>> 12));
        chk({tag, " offset_next (R5)"}, {15'd0, offset_next}, {15'd0, m_cnt == 0});
        chk({tag, " R10 reduced cur"}, cur_lr, 16'(m_cur_lr));
    endtask

    task automatic step(input bit cd, input logic [15:0] raw, input bit wr,
                        input logic [15:0] wd, input string tag);
        longint r;
        conv_done  = cd;
        conv_raw   = raw;
        host_wr    = wr;
        host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        conv_done = 1'b0;
        host_wr   = 1'b0;
        r = longint'($signed(raw));
        if (wr) begin
            m_acc  = longint'($signed(wd)) * 4096;
            m_cnt  = 0;
            m_post = 1;
        end else if (cd) begin
            if (m_cnt == 0) begin
                if (!m_post) m_acc = sat_acc(m_acc + m_cur);
                m_off = r;
            end else begin
                m_cur    = clampl(r - m_off, 15);
                m_cur_lr = clampl(r - m_off, 13);
                m_acc    = sat_acc(m_acc + m_cur);
            end
            m_post = 0;
            m_cnt  = (m_cnt + 1) % 1024;
        end
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        int          sel;
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R6 reset state");

        step(1, 16'd100, 0, 0, "R6 first conversion is offset slot");
        step(1, 16'd150, 0, 0, "R1 corrected current");
        step(1, -16'sd1000, 0, 0, "R1 negative current");
        step(0, 16'd777, 0, 0, "R2 idle");
        step(0, 16'd5, 0, 0, "R2 idle");
        step(1, 16'h8000, 0, 0, "R1 clamp low");
        step(1, 16'h7FFF, 0, 0, "R1 clamp high");

        // full period without writes: offset slot placement and hold
        for (int i = 0; i < 1030; i++) begin
            rv = 16'($urandom);
            if (i % 3 == 0) rv = 16'($signed(16'($urandom % 2001)) - 16'sd1000);
            step(1, rv, 0, 0, (m_cnt == 0) ? "R4 offset slot hold" : "R5 period");
        end

        // host write, post-write slot, resume
        step(0, 0, 1, 16'h1234, "R7 host write");
        step(1, 16'd20, 0, 0, "R8 offset slot after write adds nothing");
        step(1, 16'd500, 0, 0, "R8 accumulation resumes");

        // saturation high
        step(0, 0, 1, 16'h7FFF, "R3 preload high");
        step(1, 16'd0, 0, 0, "R3 offset slot");
        step(1, 16'h7FFF, 0, 0, "R3 saturate high");
        step(1, 16'h7FFF, 0, 0, "R3 stay high");
        // saturation low
        step(0, 0, 1, 16'h8000, "R3 preload low");
        step(1, 16'd0, 0, 0, "R3 offset slot");
        step(1, 16'h8000, 0, 0, "R3 saturate low");
        step(1, 16'h8000, 0, 0, "R3 stay low");

        // simultaneous write and conversion
        step(1, 16'd555, 1, 16'h0042, "R9 write wins");
        step(1, 16'd3, 0, 0, "R9 next is offset slot");
        step(1, 16'd10, 0, 0, "R9 resume");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            sel = int'($urandom % 200);
            rv  = 16'($urandom);
            if (sel == 0)      step(0, rv, 1, 16'($urandom), "R7 random write");
            else if (sel == 1) step(1, rv, 1, 16'($urandom), "R9 random collide");
            else if (sel < 40) step(0, rv, 0, 0, "R2 random idle");
            else               step(1, rv, 0, 0, "R2 random conversion");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule